// File: doc/BRIEF.md
# Daisy-Chained Bus Ownership Slot

This block is the per-slot arbitration logic for a shared backplane bus where priority follows the physical slot position: the slot nearest the head of the chain wins. Each board instantiates one copy. The copy takes a request from the board's own control logic and works with four shared lines. It drives a request line and a bus-owner line, which the backplane wire-ORs across all slots. It observes the combined owner line. It receives a grant from the slot above and forwards a grant to the slot below. The combined request line is looped back as the grant input of the first slot.

A request can only be placed on the chain while no slot owns the bus. When the grant reaches a slot, that slot captures its local request once. On the next clock it either takes ownership or passes the grant downward. It keeps that decision until the grant is withdrawn. An owner holds the bus until its board has stopped requesting and both the data-strobe and transfer-done lines are quiet. Two parameters pick variants. A slot that cannot be master reduces to a plain wire from grant-in to grant-out. The slot at the tail of the chain feeds its grant-out back onto the owner line, so a grant that nobody accepts collapses instead of hanging.

Top module: `busOwnerSlot`

## Requirements
- R1: While reset is held and on the first sample after it is released, reqOut, ownerDrive, grantOut and localOwner are all low.
- R2: reqOut is registered. It is high one cycle after a clock edge that sampled localReq high and ownerLine low. It is low one cycle after an edge that sampled ownerLine high.
- R3: An idle slot that samples grantIn high captures localReq at that edge. If the captured value is 1, ownerDrive and localOwner go high after the following edge and grantOut stays low.
- R4: If the captured value is 0, grantOut goes high after the following edge and ownerDrive stays low.
- R5: Changes on localReq after the capture edge do not alter the decision. A slot that captured 0 keeps passing, and a slot that captured 1 still becomes owner even if the request is withdrawn.
- R6: An owner keeps ownerDrive and localOwner high while any of localReq, strobeBusy or doneBusy is high. Both fall after the first edge that samples all three low.
- R7: After releasing the bus, a slot makes no new decision until it has sampled grantIn low. A grant that arrives after that is judged on the request present at its arrival.
- R8: A slot that is passing the grant drops grantOut after the first edge that samples grantIn low.
- R9: With MASTER_CAPABLE=0, grantOut equals grantIn within the same cycle, and reqOut, ownerDrive and localOwner stay low.
- R10: With CHAIN_END=1, ownerDrive is high whenever grantOut is high.
- R11: In a chain, the lowest-numbered slot that holds its request when the grant reaches it becomes owner. At no time do two slots own the bus.
- R12: A grant that every slot passes reaches the tail, which asserts the owner line. The chain then returns to idle, and a slot still requesting afterwards becomes owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localReq | input | 1 | Board wants bus ownership |
| strobeBusy | input | 1 | Data strobe of a transfer is active |
| doneBusy | input | 1 | Transfer-done line is active |
| ownerLine | input | 1 | Combined bus-owner line as seen on the backplane |
| grantIn | input | 1 | Grant arriving from the higher-priority neighbour |
| reqOut | output | 1 | This slot's drive onto the shared request line |
| ownerDrive | output | 1 | This slot's drive onto the shared bus-owner line |
| grantOut | output | 1 | Grant forwarded to the lower-priority neighbour |
| localOwner | output | 1 | This slot currently owns the bus |

## Verification
The properties assume the board obeys the transfer rules. strobeBusy and doneBusy only become active while this slot already owns the bus. grantIn is a clean level from the neighbour, or from the request loop, that follows the synchronous chain. The directed stimulus changes every input one time unit after a rising edge and raises the busy lines only inside an ownership period. In the chain scenarios the owner line and the grant inputs come from the wire-OR and the neighbour outputs, exactly as a backplane would connect them, so no input ever breaks the chain's own timing.

// File: rtl/busOwnerPkg.sv
package busOwnerPkg;

  typedef enum logic [2:0] {
    SlotIdle  = 3'd0,
    SlotJudge = 3'd1,
    SlotPass  = 3'd2,
    SlotOwn   = 3'd3,
    SlotDrain = 3'd4
  } slotStateT;

  typedef struct packed {
    logic captureReq;
    logic clearReq;
  } latchCtlT;

endpackage

// File: rtl/busOwnerDatapath.sv
module busOwnerDatapath
  import busOwnerPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     localReq,
  input  logic     ownerLine,
  input  latchCtlT ctl,
  output logic     reqLatched,
  output logic     reqOutQ
);

  // Request captured once per grant arrival.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqLatched <= 1'b0;
    end else if (ctl.clearReq) begin
      reqLatched <= 1'b0;
    end else if (ctl.captureReq) begin
      reqLatched <= localReq;
    end
  end

  // Chain request is only offered while nobody owns the bus.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOutQ <= 1'b0;
    end else begin
      reqOutQ <= localReq & ~ownerLine;
    end
  end

endmodule

// File: rtl/busOwnerControl.sv
module busOwnerControl
  import busOwnerPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     grantIn,
  input  logic     reqLatched,
  input  logic     localReq,
  input  logic     strobeBusy,
  input  logic     doneBusy,
  output latchCtlT ctl,
  output logic     holdsOwner,
  output logic     passesGrant
);

  slotStateT state, stateNext;
  logic      transfersQuiet;

  assign transfersQuiet = ~localReq & ~strobeBusy & ~doneBusy;

  always_comb begin
    stateNext      = state;
    ctl.captureReq = 1'b0;
    ctl.clearReq   = 1'b0;
    unique case (state)
      SlotIdle: begin
        if (grantIn) begin
          ctl.captureReq = 1'b1;
          stateNext      = SlotJudge;
        end
      end
      SlotJudge: begin
        if (!grantIn) begin
          ctl.clearReq = 1'b1;
          stateNext    = SlotIdle;
        end else if (reqLatched) begin
          stateNext = SlotOwn;
        end else begin
          stateNext = SlotPass;
        end
      end
      SlotPass: begin
        if (!grantIn) begin
          ctl.clearReq = 1'b1;
          stateNext    = SlotIdle;
        end
      end
      SlotOwn: begin
        if (transfersQuiet) begin
          stateNext = SlotDrain;
        end
      end
      SlotDrain: begin
        if (!grantIn) begin
          ctl.clearReq = 1'b1;
          stateNext    = SlotIdle;
        end
      end
      default: begin
        ctl.clearReq = 1'b1;
        stateNext    = SlotIdle;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SlotIdle;
    end else begin
      state <= stateNext;
    end
  end

  assign holdsOwner  = (state == SlotOwn);
  assign passesGrant = (state == SlotPass);

endmodule

// File: rtl/busOwnerSlot.sv
module busOwnerSlot
  import busOwnerPkg::*;
#(
  parameter bit MASTER_CAPABLE = 1'b1,
  parameter bit CHAIN_END      = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic localReq,
  input  logic strobeBusy,
  input  logic doneBusy,
  input  logic ownerLine,
  input  logic grantIn,
  output logic reqOut,
  output logic ownerDrive,
  output logic grantOut,
  output logic localOwner
);

  logic coreOwner;

  generate
    if (MASTER_CAPABLE) begin : gMaster
      latchCtlT latchCtl;
      logic     reqLatched;
      logic     reqOutQ;
      logic     holdsOwner;
      logic     passesGrant;

      busOwnerControl ctrl_i (
        .clk        (clk),
        .rstN       (rstN),
        .grantIn    (grantIn),
        .reqLatched (reqLatched),
        .localReq   (localReq),
        .strobeBusy (strobeBusy),
        .doneBusy   (doneBusy),
        .ctl        (latchCtl),
        .holdsOwner (holdsOwner),
        .passesGrant(passesGrant)
      );

      busOwnerDatapath dp_i (
        .clk       (clk),
        .rstN      (rstN),
        .localReq  (localReq),
        .ownerLine (ownerLine),
        .ctl       (latchCtl),
        .reqLatched(reqLatched),
        .reqOutQ   (reqOutQ)
      );

      assign reqOut     = reqOutQ;
      assign coreOwner  = holdsOwner;
      assign grantOut   = passesGrant;
      assign localOwner = holdsOwner;
    end else begin : gJumper
      logic unusedJumperInputs;
      assign unusedJumperInputs = ^{clk, rstN, localReq, strobeBusy, doneBusy, ownerLine};
      assign reqOut     = 1'b0;
      assign coreOwner  = 1'b0;
      assign grantOut   = grantIn;
      assign localOwner = 1'b0;
    end
  endgenerate

  generate
    if (CHAIN_END) begin : gTail
      assign ownerDrive = coreOwner | grantOut;
    end else begin : gInner
      assign ownerDrive = coreOwner;
    end
  endgenerate

endmodule

// File: rtl/busOwnerSlotChk.sv
module busOwnerSlotChk #(
  parameter bit MASTER_CAPABLE = 1'b1,
  parameter bit CHAIN_END      = 1'b0
) (
  input logic clk,
  input logic rstN,
  input logic localReq,
  input logic strobeBusy,
  input logic doneBusy,
  input logic ownerLine,
  input logic grantIn,
  input logic reqOut,
  input logic ownerDrive,
  input logic grantOut,
  input logic localOwner
);

  logic unusedChk;
  assign unusedChk = ^{ownerDrive, localReq, strobeBusy, doneBusy, ownerLine, grantIn, grantOut};

  generate
    if (MASTER_CAPABLE) begin : gMasterChk
      // R2: a seen owner blocks the chain request on the next cycle
      assert_req_blocked_R2: assert property (@(posedge clk) disable iff (!rstN)
        ownerLine |=> !reqOut);

      // R3: ownership only starts while the grant is present
      assert_owner_needs_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(localOwner) |-> $past(grantIn));

      // R4: a slot never both owns and forwards the grant
      assert_own_or_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
        !(localOwner && grantOut));

      // R6: no release while board is requesting or a transfer is active
      assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
        (localOwner && (localReq || strobeBusy || doneBusy)) |=> localOwner);

      // R7: a released slot does not grab the bus on the very next cycle
      assert_no_regrab_R7: assert property (@(posedge clk) disable iff (!rstN)
        $fell(localOwner) |=> !localOwner);

      // R8: forwarded grant falls after the incoming grant is seen low
      assert_pass_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
        (grantOut && !grantIn) |=> !grantOut);
    end else begin : gJumperChk
      // R9: a non-master slot never requests or owns
      assert_jumper_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
        !reqOut && !localOwner);
    end
  endgenerate

endmodule

bind busOwnerSlot busOwnerSlotChk #(
  .MASTER_CAPABLE(MASTER_CAPABLE),
  .CHAIN_END     (CHAIN_END)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .localReq  (localReq),
  .strobeBusy(strobeBusy),
  .doneBusy  (doneBusy),
  .ownerLine (ownerLine),
  .grantIn   (grantIn),
  .reqOut    (reqOut),
  .ownerDrive(ownerDrive),
  .grantOut  (grantOut),
  .localOwner(localOwner)
);

// File: tb/busOwnerSlot_tb_top.sv
module busOwnerSlot_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int SLOTS      = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int   total = 0;
  int   bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- single slot under direct stimulus ----------------
  logic uReq = 1'b0, uStrobe = 1'b0, uDone = 1'b0, uOwner = 1'b0, uGrant = 1'b0;
  logic uReqOut, uOwnDrv, uGrantOut, uLocOwn;

  busOwnerSlot dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .localReq  (uReq),
    .strobeBusy(uStrobe),
    .doneBusy  (uDone),
    .ownerLine (uOwner),
    .grantIn   (uGrant),
    .reqOut    (uReqOut),
    .ownerDrive(uOwnDrv),
    .grantOut  (uGrantOut),
    .localOwner(uLocOwn)
  );

  // ---------------- four-slot chain: slot 2 is a jumper, slot 3 the tail ----------------
  logic [SLOTS-1:0] cReq = '0;
  wire  [SLOTS-1:0] cReqOut, cOwnDrv, cGrantOut, cLocOwn, cGrantIn;
  wire              cOwnerLine = |cOwnDrv;
  assign cGrantIn = {cGrantOut[SLOTS-2:0], |cReqOut};

  for (genvar s = 0; s < SLOTS; s++) begin : gChain
    busOwnerSlot #(
      .MASTER_CAPABLE(s != 2),
      .CHAIN_END     (s == SLOTS - 1)
    ) slot_i (
      .clk       (clk),
      .rstN      (rstN),
      .localReq  (cReq[s]),
      .strobeBusy(1'b0),
      .doneBusy  (1'b0),
      .ownerLine (cOwnerLine),
      .grantIn   (cGrantIn[s]),
      .reqOut    (cReqOut[s]),
      .ownerDrive(cOwnDrv[s]),
      .grantOut  (cGrantOut[s]),
      .localOwner(cLocOwn[s])
    );
  end

  // ---------------- continuous observers ----------------
  int multiOwner = 0, tailBad = 0, jumperBad = 0;
  bit sawJumperGrant = 1'b0, sawTailTie = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if ($countones(cLocOwn) > 1) multiOwner++;
      if (cGrantOut[3] && !cOwnDrv[3]) tailBad++;
      if (cGrantOut[3] && cOwnDrv[3] && !cLocOwn[3]) sawTailTie = 1'b1;
      if ((cGrantOut[2] != cGrantIn[2]) || cReqOut[2] || cOwnDrv[2] || cLocOwn[2]) jumperBad++;
      if (cGrantIn[2]) sawJumperGrant = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    rstN = 1'b0;
    repeat (3) step();
    check({uReqOut, uOwnDrv, uGrantOut, uLocOwn} == 4'b0, "R1 unit outputs in reset",
          {uReqOut, uOwnDrv, uGrantOut, uLocOwn}, 0);
    rstN = 1'b1;
    step();
    check({uReqOut, uOwnDrv, uGrantOut, uLocOwn} == 4'b0, "R1 unit outputs after reset",
          {uReqOut, uOwnDrv, uGrantOut, uLocOwn}, 0);
    check(cOwnDrv == '0 && cGrantOut == '0, "R1 chain idle after reset", cOwnDrv, 0);
  endtask

  task automatic tRequestGate();
    uReq = 1'b1; uOwner = 1'b0;
    step();
    check(uReqOut == 1'b1, "R2 request offered when no owner", uReqOut, 1);
    uOwner = 1'b1;
    step();
    check(uReqOut == 1'b0, "R2 request withdrawn when owner seen", uReqOut, 0);
    uOwner = 1'b0; uReq = 1'b0;
    step();
  endtask

  task automatic tOwnHoldRelease();
    uReq = 1'b1; uGrant = 1'b1;
    step();
    check(uOwnDrv == 1'b0, "R3 no ownership on capture edge", uOwnDrv, 0);
    step();
    check(uOwnDrv == 1'b1 && uLocOwn == 1'b1, "R3 ownership after judge", uLocOwn, 1);
    check(uGrantOut == 1'b0, "R3 grant not forwarded by owner", uGrantOut, 0);
    uReq = 1'b0; uStrobe = 1'b1;
    step();
    check(uLocOwn == 1'b1, "R6 held during strobe", uLocOwn, 1);
    uStrobe = 1'b0; uDone = 1'b1;
    step();
    check(uLocOwn == 1'b1, "R6 held during done", uLocOwn, 1);
    uDone = 1'b0;
    step();
    check(uLocOwn == 1'b0 && uOwnDrv == 1'b0, "R6 released when quiet", uLocOwn, 0);
    uReq = 1'b1;
    step();
    step();
    check(uLocOwn == 1'b0 && uGrantOut == 1'b0, "R7 no new decision while grant stays high",
          {uLocOwn, uGrantOut}, 0);
    uGrant = 1'b0;
    step();
    uGrant = 1'b1;
    step();
    step();
    check(uLocOwn == 1'b1, "R7 fresh grant judged anew", uLocOwn, 1);
    uReq = 1'b0;
    step();
    uGrant = 1'b0;
    step();
  endtask

  task automatic tPassIgnore();
    uReq = 1'b0; uGrant = 1'b1;
    step();
    uReq = 1'b1;
    step();
    check(uGrantOut == 1'b1 && uOwnDrv == 1'b0, "R4 grant forwarded when captured 0",
          {uGrantOut, uOwnDrv}, 2);
    step();
    check(uGrantOut == 1'b1 && uLocOwn == 1'b0, "R5 late request ignored", {uGrantOut, uLocOwn}, 2);
    uGrant = 1'b0;
    step();
    check(uGrantOut == 1'b0, "R8 forwarded grant dropped", uGrantOut, 0);
    uReq = 1'b0;
    step();
  endtask

  task automatic tLatchedWithdraw();
    uReq = 1'b1; uGrant = 1'b1;
    step();
    uReq = 1'b0;
    step();
    check(uLocOwn == 1'b1, "R5 captured request still wins", uLocOwn, 1);
    step();
    check(uLocOwn == 1'b0, "R6 immediate release when quiet", uLocOwn, 0);
    uGrant = 1'b0;
    step();
  endtask

  task automatic waitOwner(input int idx, input string tag);
    int n = 0;
    while (!cLocOwn[idx] && n < 40) begin
      step();
      n++;
    end
    check(cLocOwn[idx] == 1'b1, tag, cLocOwn, 1 << idx);
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while ((cOwnerLine || cGrantIn != '0) && n < 40) begin
      step();
      n++;
    end
    check(!cOwnerLine && cGrantIn == '0, tag, {cOwnerLine, cGrantIn}, 0);
  endtask

  task automatic tChainPriority();
    cReq = 4'b1010;
    waitOwner(1, "R11 higher-priority requester wins");
    check(cLocOwn == 4'b0010, "R11 only one owner", cLocOwn, 2);
    cReq[1] = 1'b0;
    waitOwner(3, "R11 remaining requester wins next");
    cReq = '0;
    waitIdle("R11 chain idle after release");
  endtask

  task automatic tChainTail();
    cReq[1] = 1'b1;
    step();
    step();
    // slot 0 has just captured 0: it now raises a request, slot 1 withdraws
    cReq[0] = 1'b1; cReq[1] = 1'b0;
    waitOwner(0, "R12 waiting requester owns after unused grant");
    check(sawTailTie, "R12 tail tie reached owner line", sawTailTie, 1);
    check(tailBad == 0, "R10 tail owner drive follows grant", tailBad, 0);
    cReq = '0;
    waitIdle("R12 chain idle afterwards");
  endtask

  task automatic tFinalObservers();
    check(multiOwner == 0, "R11 never two owners", multiOwner, 0);
    check(sawJumperGrant, "R9 jumper saw a grant", sawJumperGrant, 1);
    check(jumperBad == 0, "R9 jumper passes grant and stays silent", jumperBad, 0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    tReset();
    tRequestGate();
    tOwnHoldRelease();
    tPassIgnore();
    tLatchedWithdraw();
    tChainPriority();
    tChainTail();
    tFinalObservers();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule